// File: doc/BRIEF.md
# Two-Channel DMA Control Register File

This block holds the host-visible control state of a two-channel bus-master disk DMA engine. Every channel has a command byte, a status byte and a 32-bit descriptor-table base address. The host reaches them through a byte-addressed port that accepts byte, halfword and word accesses. The block drives a one-cycle start strobe and a direction bit to the transfer engine for each channel. It also presents a current descriptor pointer, which is reloaded on every base-address write. It takes per-channel completion and error indications back from the engine.

A stop request never aborts a transfer in flight. The channel stays active until the engine reports that it has finished. Error and interrupt flags are sticky and are cleared by writing 1 to them. Host writes to the address register can replace any byte lane or lane pair. The two lowest address bits always stay zero.

Top module: `dma_ctl_regfile`

## Requirements
- R1: A command write keeps only data bit 0 (go) and bit 3 (direction). The command byte reads back with all other bits zero, and bit 3 drives `eng_dir` of that channel.
- R2: Writing go=1 while the channel's active flag (status bit 0) is clear sets the active flag and raises `eng_start` of that channel for exactly one cycle, in the cycle after the write.
- R3: Writing go=1 while the channel is already active updates the command byte and raises no new start strobe.
- R4: Writing go=0 does not clear the active flag. It stays set until `eng_done` or `eng_err` of that channel is seen.
- R5: `eng_done` clears the active flag and sets the interrupt flag (status bit 2). `eng_err` clears the active flag and sets both the error flag (status bit 1) and the interrupt flag.
- R6: A status write clears error and interrupt flags where the data bit is 1 and leaves them alone where it is 0. The active flag cannot be written.
- R7: Address writes replace only the addressed lanes. A byte write puts data[7:0] into lane L = offset[1:0] (bits 8L+7:8L). A halfword write puts data[15:0] at bit 8L; lanes above 3 are dropped. A word write replaces the whole value.
- R8: Bits 1:0 of the stored base address are always zero.
- R9: Every write to the address register, of any width, copies the new base value onto `eng_ptr` of that channel.
- R10: Byte and halfword reads of the address register return the base shifted right by 8L and masked to 8 or 16 bits. A word read returns the full base.
- R11: Inside a channel, offset 0 is command, offset 2 is status and offsets 4 to 7 are the address. Channel n starts at byte 8n, other offsets read zero, and the channels share no state.
- R12: After reset every register, strobe and pointer is zero. Read data appears on `host_rdata` in the cycle after `host_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 4 | Byte offset into the register space |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data, right-aligned |
| eng_start | output | 2 | Per-channel start strobe |
| eng_dir | output | 2 | Per-channel direction bit |
| eng_ptr | output | 64 | Per-channel current descriptor pointer, channel n at bits 32n+31:32n |
| eng_done | input | 2 | Per-channel transfer completion |
| eng_err | input | 2 | Per-channel transfer error |

## Verification
The hardest state to reach is a channel that is already active when a new command arrives. This covers both a go=1 write, which must not strobe again, and a go=0 write, which must not stop the transfer. The bench holds the engine side silent after a launch, so the channel stays active while it issues these writes. It only then pulses completion or error and checks that the flags settle. Lane handling of the address register is driven through a chain of byte and halfword writes on top of a known word value, so a single read exposes every wrongly replaced lane.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

   localparam int REG_W = 32;
   localparam int LANES = REG_W / 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;

   localparam int CMD_GO  = 0;
   localparam int CMD_DIR = 3;
   localparam int ST_ACT  = 0;
   localparam int ST_ERR  = 1;
   localparam int ST_IRQ  = 2;

   function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] lane);
      logic [LANES-1:0] m;
      case (sz)
         SZ_BYTE: m = LANES'(1) << lane;
         SZ_HALF: m = LANES'(3) << lane;
         default: m = '1;
      endcase
      return m;
   endfunction

   function automatic logic [REG_W-1:0] size_mask(acc_size_e sz);
      logic [REG_W-1:0] m;
      case (sz)
         SZ_BYTE: m = REG_W'(32'h0000_00FF);
         SZ_HALF: m = REG_W'(32'h0000_FFFF);
         default: m = '1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/dma_ctl_chan.sv
module dma_ctl_chan
   import dma_ctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cmd,
   input  logic             wr_stat,
   input  logic             wr_base,
   input  acc_size_e        size,
   input  logic [1:0]       lane,
   input  logic [REG_W-1:0] wdata,
   input  logic             done,
   input  logic             err,
   output logic             start_o,
   output logic             dir_o,
   output logic             act_o,
   output logic [7:0]       cmd_o,
   output logic [7:0]       stat_o,
   output logic [REG_W-1:0] base_o,
   output logic [REG_W-1:0] ptr_o
);

   logic             go_q, dir_q, act_q, err_q, irq_q, start_q;
   logic [REG_W-1:0] base_q, ptr_q;
   logic             launch;
   logic [LANES-1:0] lmask;
   logic [REG_W-1:0] shifted, merged;

   assign launch  = wr_cmd & wdata[CMD_GO] & ~act_q;
   assign lmask   = lane_mask(size, lane);
   assign shifted = (size == SZ_BYTE || size == SZ_HALF) ? (wdata << (8 * lane)) : wdata;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = lmask[i] ? shifted[8*i +: 8] : base_q[8*i +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_q    <= 1'b0;
         dir_q   <= 1'b0;
         act_q   <= 1'b0;
         err_q   <= 1'b0;
         irq_q   <= 1'b0;
         start_q <= 1'b0;
         base_q  <= '0;
         ptr_q   <= '0;
      end else begin
         start_q <= launch;
         if (wr_cmd) begin
            go_q  <= wdata[CMD_GO];
            dir_q <= wdata[CMD_DIR];
         end
         act_q <= (act_q & ~(done | err)) | launch;
         err_q <= err | (err_q & ~(wr_stat & wdata[ST_ERR]));
         irq_q <= done | err | (irq_q & ~(wr_stat & wdata[ST_IRQ]));
         if (wr_base) begin
            base_q <= {merged[REG_W-1:2], 2'b00};
            ptr_q  <= {merged[REG_W-1:2], 2'b00};
         end
      end
   end

   always_comb begin
      cmd_o          = '0;
      cmd_o[CMD_GO]  = go_q;
      cmd_o[CMD_DIR] = dir_q;
      stat_o         = '0;
      stat_o[ST_ACT] = act_q;
      stat_o[ST_ERR] = err_q;
      stat_o[ST_IRQ] = irq_q;
   end

   assign start_o = start_q;
   assign dir_o   = dir_q;
   assign act_o   = act_q;
   assign base_o  = base_q;
   assign ptr_o   = ptr_q;

endmodule

// File: rtl/dma_ctl_rdmux.sv
module dma_ctl_rdmux
   import dma_ctl_pkg::*;
#(
   parameter int CH_COUNT = 2,
   parameter bit RD_PIPE  = 1'b1,
   localparam int CH_IW   = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd,
   input  logic                      hit,
   input  logic [CH_IW-1:0]          ch_idx,
   input  logic [2:0]                ofs,
   input  acc_size_e                 size,
   input  logic [CH_COUNT*8-1:0]     cmd_all,
   input  logic [CH_COUNT*8-1:0]     stat_all,
   input  logic [CH_COUNT*REG_W-1:0] base_all,
   output logic [REG_W-1:0]          rdata
);

   logic [REG_W-1:0] rval;
   logic [REG_W-1:0] base_sel;
   logic [7:0]       cmd_sel, stat_sel;

   always_comb begin
      base_sel = '0;
      cmd_sel  = '0;
      stat_sel = '0;
      for (int c = 0; c < CH_COUNT; c++) begin
         if (ch_idx == CH_IW'(c)) begin
            base_sel = base_all[c*REG_W +: REG_W];
            cmd_sel  = cmd_all[c*8 +: 8];
            stat_sel = stat_all[c*8 +: 8];
         end
      end
   end

   always_comb begin
      rval = '0;
      if (hit) begin
         if (ofs == OFS_CMD)
            rval = REG_W'(cmd_sel);
         else if (ofs == OFS_STAT)
            rval = REG_W'(stat_sel);
         else if (ofs[2]) begin
            if (size == SZ_BYTE || size == SZ_HALF)
               rval = (base_sel >> (8 * ofs[1:0])) & size_mask(size);
            else
               rval = base_sel;
         end
      end
   end

   if (RD_PIPE) begin : g_pipe
      logic [REG_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (rd)
            rdata_q <= rval;
      end
      assign rdata = rdata_q;
   end else begin : g_comb
      assign rdata = rd ? rval : '0;
   end

endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
   import dma_ctl_pkg::*;
#(
   parameter int CH_COUNT  = 2,
   parameter bit RD_PIPE   = 1'b1,
   localparam int HOST_AW  = 3 + ((CH_COUNT > 1) ? $clog2(CH_COUNT) : 0),
   localparam int CH_IW    = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_wr,
   input  logic                      host_rd,
   input  logic [HOST_AW-1:0]        host_addr,
   input  logic [1:0]                host_size,
   input  logic [REG_W-1:0]          host_wdata,
   output logic [REG_W-1:0]          host_rdata,
   output logic [CH_COUNT-1:0]       eng_start,
   output logic [CH_COUNT-1:0]       eng_dir,
   output logic [CH_COUNT*REG_W-1:0] eng_ptr,
   input  logic [CH_COUNT-1:0]       eng_done,
   input  logic [CH_COUNT-1:0]       eng_err
);

   if (CH_COUNT < 1 || CH_COUNT > 8) begin : g_bad_count
      $error("dma_ctl_regfile: CH_COUNT must lie in 1..8");
   end
   if (REG_W != 32) begin : g_bad_width
      $error("dma_ctl_regfile: register width must be 32");
   end

   acc_size_e                 size;
   logic [CH_IW-1:0]          ch_idx;
   logic                      hit;
   logic [2:0]                ofs;
   logic [CH_COUNT-1:0]       wr_cmd_w, wr_stat_w, wr_base_w, act_w;
   logic [CH_COUNT*8-1:0]     cmd_w, stat_w;
   logic [CH_COUNT*REG_W-1:0] base_w;

   assign size = acc_size_e'(host_size);
   assign ofs  = host_addr[2:0];

   if (CH_COUNT > 1) begin : g_multi
      assign ch_idx = host_addr[HOST_AW-1:3];
      assign hit    = (int'(ch_idx) < CH_COUNT);
   end else begin : g_single
      assign ch_idx = 1'b0;
      assign hit    = 1'b1;
   end

   for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
      logic sel;
      assign sel          = hit && (ch_idx == CH_IW'(c));
      assign wr_cmd_w[c]  = host_wr && sel && (ofs == OFS_CMD);
      assign wr_stat_w[c] = host_wr && sel && (ofs == OFS_STAT);
      assign wr_base_w[c] = host_wr && sel && ofs[2];

      dma_ctl_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cmd  (wr_cmd_w[c]),
         .wr_stat (wr_stat_w[c]),
         .wr_base (wr_base_w[c]),
         .size    (size),
         .lane    (ofs[1:0]),
         .wdata   (host_wdata),
         .done    (eng_done[c]),
         .err     (eng_err[c]),
         .start_o (eng_start[c]),
         .dir_o   (eng_dir[c]),
         .act_o   (act_w[c]),
         .cmd_o   (cmd_w[c*8 +: 8]),
         .stat_o  (stat_w[c*8 +: 8]),
         .base_o  (base_w[c*REG_W +: REG_W]),
         .ptr_o   (eng_ptr[c*REG_W +: REG_W])
      );
   end

   dma_ctl_rdmux #(
      .CH_COUNT (CH_COUNT),
      .RD_PIPE  (RD_PIPE)
   ) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (host_rd),
      .hit      (hit),
      .ch_idx   (ch_idx),
      .ofs      (ofs),
      .size     (size),
      .cmd_all  (cmd_w),
      .stat_all (stat_w),
      .base_all (base_w),
      .rdata    (host_rdata)
   );

endmodule

// File: rtl/dma_ctl_regfile_chk.sv
module dma_ctl_regfile_chk #(
   parameter int CH_COUNT = 2,
   parameter int REG_W    = 32
)(
   input logic                      clk,
   input logic                      rst_n,
   input logic [CH_COUNT-1:0]       start,
   input logic [CH_COUNT-1:0]       act,
   input logic [CH_COUNT-1:0]       done,
   input logic [CH_COUNT-1:0]       err,
   input logic [CH_COUNT-1:0]       wr_base,
   input logic [CH_COUNT*REG_W-1:0] base,
   input logic [CH_COUNT*REG_W-1:0] ptr
);

   for (genvar c = 0; c < CH_COUNT; c++) begin : g_chk
      // R2: the active flag rising comes with a start strobe
      p_launch_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(act[c]) |-> start[c]);
      // R2: the strobe lasts a single cycle
      p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
         start[c] |=> !start[c]);
      // R3: no strobe while the channel was already active
      p_no_restrobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
         start[c] |-> !$past(act[c]));
      // R4: active holds until the engine reports back
      p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (act[c] && !done[c] && !err[c]) |=> act[c]);
      // R5: completion or error drops the active flag unless relaunched
      p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (act[c] && (done[c] || err[c])) |=> !act[c]);
      // R8: the pointer low bits stay zero
      p_ptr_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ptr[c*REG_W +: 2] == 2'b00);
      // R9: every address write leaves the pointer equal to the base
      p_ptr_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_base[c] |=> (ptr[c*REG_W +: REG_W] == base[c*REG_W +: REG_W]));
   end

endmodule

bind dma_ctl_regfile dma_ctl_regfile_chk #(
   .CH_COUNT (CH_COUNT),
   .REG_W    (dma_ctl_pkg::REG_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (eng_start),
   .act     (act_w),
   .done    (eng_done),
   .err     (eng_err),
   .wr_base (wr_base_w),
   .base    (base_w),
   .ptr     (eng_ptr)
);

// File: tb/dma_ctl_regfile_tb.sv
`timescale 1ns/1ps
module dma_ctl_regfile_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [1:0]  host_size = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [1:0]  eng_start, eng_dir;
   logic [63:0] eng_ptr;
   logic [1:0]  eng_done = '0, eng_err = '0;

   int total = 0, bad = 0;
   int strobes0 = 0, strobes1 = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dma_ctl_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .eng_start(eng_start), .eng_dir(eng_dir),
      .eng_ptr(eng_ptr), .eng_done(eng_done), .eng_err(eng_err)
   );

   always @(negedge clk) begin
      if (eng_start[0]) strobes0++;
      if (eng_start[1]) strobes1++;
   end

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
      host_wr = 1'b1; host_addr = a; host_size = sz; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, logic [1:0] sz, output logic [31:0] d);
      host_rd = 1'b1; host_addr = a; host_size = sz;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_eng(bit is_err, int ch);
      if (is_err) eng_err[ch] = 1'b1; else eng_done[ch] = 1'b1;
      @(negedge clk);
      eng_err = '0; eng_done = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'h0, 2'd0, v); check("R12 cmd0 reset", v, 32'h0);
      rd(4'h2, 2'd0, v); check("R12 stat0 reset", v, 32'h0);
      rd(4'h4, 2'd2, v); check("R12 addr0 reset", v, 32'h0);
      check("R12 ptr reset", eng_ptr[31:0], 32'h0);
      check("R12 strobe reset", {30'b0, eng_start}, 32'h0);
   endtask

   task automatic t_cmd_mask();
      logic [31:0] v;
      wr(4'h0, 2'd0, 32'h0000_00FE);
      idle(1);
      rd(4'h0, 2'd0, v); check("R1 cmd keeps dir only", v, 32'h08);
      check("R1 dir output", {31'b0, eng_dir[0]}, 32'h1);
      check("R1 no strobe with go=0", strobes0, 0);
   endtask

   task automatic t_launch_and_hold();
      logic [31:0] v;
      wr(4'h0, 2'd0, 32'h0000_0001);
      idle(1);
      check("R2 one strobe", strobes0, 1);
      rd(4'h2, 2'd0, v); check("R2 active set", v, 32'h01);
      check("R1 dir cleared", {31'b0, eng_dir[0]}, 32'h0);
      wr(4'h0, 2'd0, 32'h0000_0009);
      idle(2);
      check("R3 no restrobe", strobes0, 1);
      rd(4'h0, 2'd0, v); check("R3 cmd updated", v, 32'h09);
      wr(4'h0, 2'd0, 32'h0000_0000);
      idle(2);
      rd(4'h2, 2'd0, v); check("R4 stop deferred", v, 32'h01);
      rd(4'h0, 2'd0, v); check("R4 cmd go cleared", v, 32'h00);
      pulse_eng(1'b0, 0);
      rd(4'h2, 2'd0, v); check("R5 done sets irq", v, 32'h04);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(4'h2, 2'd0, 32'h0000_0000);
      rd(4'h2, 2'd0, v); check("R6 write 0 keeps", v, 32'h04);
      wr(4'h2, 2'd0, 32'h0000_0004);
      rd(4'h2, 2'd0, v); check("R6 write 1 clears", v, 32'h00);
      wr(4'h0, 2'd0, 32'h0000_0001);
      idle(1);
      check("R2 relaunch strobe", strobes0, 2);
      wr(4'h2, 2'd0, 32'h0000_0001);
      rd(4'h2, 2'd0, v); check("R6 active not writable", v, 32'h01);
      pulse_eng(1'b1, 0);
      rd(4'h2, 2'd0, v); check("R5 err sets err and irq", v, 32'h06);
      wr(4'h2, 2'd0, 32'h0000_0002);
      rd(4'h2, 2'd0, v); check("R6 clear err only", v, 32'h04);
      wr(4'h2, 2'd0, 32'h0000_00FF);
      rd(4'h2, 2'd0, v); check("R6 clear all", v, 32'h00);
   endtask

   task automatic t_address();
      logic [31:0] v;
      wr(4'h4, 2'd2, 32'h1234_5677);
      rd(4'h4, 2'd2, v); check("R8 word write low bits", v, 32'h1234_5674);
      check("R9 ptr after word", eng_ptr[31:0], 32'h1234_5674);
      wr(4'h5, 2'd0, 32'h0000_00AB);
      rd(4'h4, 2'd2, v); check("R7 byte lane 1", v, 32'h1234_AB74);
      check("R9 ptr after byte", eng_ptr[31:0], 32'h1234_AB74);
      wr(4'h6, 2'd1, 32'h0000_BEEF);
      rd(4'h4, 2'd2, v); check("R7 half lane 2", v, 32'hBEEF_AB74);
      wr(4'h4, 2'd0, 32'h0000_00FF);
      rd(4'h4, 2'd2, v); check("R8 byte lane 0 low bits", v, 32'hBEEF_ABFC);
      check("R9 ptr after lane 0", eng_ptr[31:0], 32'hBEEF_ABFC);
      wr(4'h7, 2'd1, 32'h0000_1155);
      rd(4'h4, 2'd2, v); check("R7 half lane 3 drops upper", v, 32'h55EF_ABFC);
      rd(4'h5, 2'd0, v); check("R10 byte read lane 1", v, 32'h0000_00AB);
      rd(4'h6, 2'd1, v); check("R10 half read lane 2", v, 32'h0000_55EF);
      rd(4'h5, 2'd1, v); check("R10 half read lane 1", v, 32'h0000_EFAB);
      rd(4'h7, 2'd0, v); check("R10 byte read lane 3", v, 32'h0000_0055);
   endtask

   task automatic t_channels();
      logic [31:0] v;
      wr(4'hC, 2'd2, 32'hCAFE_F00D);
      rd(4'hC, 2'd2, v); check("R11 ch1 address", v, 32'hCAFE_F00C);
      check("R9 ch1 ptr", eng_ptr[63:32], 32'hCAFE_F00C);
      rd(4'h4, 2'd2, v); check("R11 ch0 untouched", v, 32'h55EF_ABFC);
      wr(4'h8, 2'd0, 32'h0000_0009);
      idle(1);
      check("R11 ch1 strobe", strobes1, 1);
      check("R11 ch0 no strobe", strobes0, 2);
      rd(4'hA, 2'd0, v); check("R11 ch1 active", v, 32'h01);
      rd(4'h2, 2'd0, v); check("R11 ch0 idle", v, 32'h00);
      rd(4'h3, 2'd0, v); check("R11 hole reads zero", v, 32'h00);
      check("R1 ch1 dir", {30'b0, eng_dir}, 32'h2);
      pulse_eng(1'b0, 1);
      rd(4'hA, 2'd0, v); check("R5 ch1 done", v, 32'h04);
      rd(4'h2, 2'd0, v); check("R11 ch0 no irq", v, 32'h00);
   endtask

   task automatic t_rd_hold();
      logic [31:0] v;
      rd(4'hC, 2'd2, v);
      idle(3);
      check("R12 read data holds", host_rdata, 32'hCAFE_F00C);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_cmd_mask();
      t_launch_and_hold();
      t_w1c();
      t_address();
      t_channels();
      t_rd_hold();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule